// File: doc/BRIEF.md
# Floppy Controller Phase and Status Tracker

This block follows the host side of a floppy disk controller's command protocol. It watches data-port writes and reads and works out whether the controller is taking command bytes, running an execution phase, or handing back result bytes. From that it produces the 8-bit main status word that host software polls before every data-port access. A small built-in command table gives the byte count, the number of result bytes and whether there is an execution phase for four command classes: seek, recalibrate, sense-interrupt and a data-transfer command. Every other opcode is treated as invalid.

The status word also carries one busy flag for each drive. A seek or recalibrate sets the flag of the drive it targets. A later sense-interrupt reports the lowest-numbered busy drive and clears that flag when the host reads the first result byte. The status stays at zero after reset until the oscillator-stable input is seen. Accesses that come in the wrong direction or while the controller is not ready are dropped and recorded in a sticky error flag.

Top module: `fdc_phase_status`

## Requirements
- R1: The status word is laid out as: bit 7 ready-for-host, bit 6 direction (0 = host writes, 1 = host reads), bit 5 non-DMA execution, bit 4 command busy, bits 3..0 busy flags of drives 3..0. While idle with no drive busy it reads 80h.
- R2: An accepted data-port transfer clears the ready bit in the next cycle. The bit comes back RDY_LAT cycles later (default 2).
- R3: Command busy sets in the cycle after the first command byte is accepted. It clears after the last result byte is read, or after the last command byte when the command has no result bytes.
- R4: Seek (opcode 0Fh, 3 bytes) and recalibrate (opcode 07h, 2 bytes) have no result bytes. Each takes its drive number from bits 1..0 of its second byte and sets that drive's busy flag when its last byte is accepted.
- R5: Sense-interrupt (opcode 08h) is one byte with two result bytes. The first result byte is {6'b0, drive} for the lowest-numbered busy drive, or 80h when no drive is busy. Reading that byte clears the reported drive's busy flag. The second result byte is 00h.
- R6: After reset the status reads 00h until osc_stable has been high at a clock edge. From the edge after that it reads 80h.
- R7: A data-transfer command (opcode bits 4..0 = 06h, XFER_CMD_BYTES bytes, default 9) enters execution after its last byte. Execution shows status 70h, with the ready bit equal to irq, which is 0. An exec_done pulse moves it to a result phase of XFER_RES_BYTES (default 7) bytes of 00h, with status D0h and irq high.
- R8: Any other opcode is a one-byte command with a single result byte of 80h. Status D0h is shown while that byte is pending.
- R9: An exec_done pulse outside an execution phase has no effect.
- R10: A write while the direction bit is 1, a read while it is 0, or any access while the ready bit is 0 is ignored and sets proto_err. proto_err stays set until reset.
- R11: Reset returns the phase to idle and clears all drive busy flags and proto_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_stable | input | 1 | Oscillator has settled |
| dat_wr | input | 1 | Host data-port write strobe, one cycle per byte |
| dat_wdata | input | 8 | Byte written by the host |
| dat_rd | input | 1 | Host data-port read strobe, one cycle per byte |
| exec_done | input | 1 | One-cycle pulse marking the end of an execution phase |
| status | output | 8 | Main status word |
| rd_data | output | 8 | Result byte presented to the host during a read |
| irq | output | 1 | Interrupt, high while result bytes are pending |
| proto_err | output | 1 | Sticky flag for an ignored access |

## Verification
The assertions assume the host drives at most one strobe in any cycle and raises exec_done only as a single-cycle pulse. They also assume reset is held across at least one clock edge, so that the busy-flag and error properties start from known values. The bench issues protocol-correct accesses only after it has polled the ready bit. It breaks the protocol on purpose only in marked steps, each with a single isolated strobe, and then checks that the status word and the following result bytes were not changed.

// File: rtl/fdc_pst_pkg.sv
package fdc_pst_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CMD,
      PH_EXEC,
      PH_RES
   } phase_e;

   typedef enum logic [2:0] {
      CK_SEEK,
      CK_RECAL,
      CK_SENSE,
      CK_XFER,
      CK_BAD
   } cmd_kind_e;

   localparam logic [7:0] OP_SEEK    = 8'h0F;
   localparam logic [7:0] OP_RECAL   = 8'h07;
   localparam logic [7:0] OP_SENSE   = 8'h08;
   localparam logic [4:0] OP_XFER_LO = 5'h06;

   localparam logic [7:0] RES_INVALID = 8'h80;

   localparam int DRV_W  = 2;
   localparam int SB_RQM = 7;
   localparam int SB_DIO = 6;
   localparam int SB_NDM = 5;
   localparam int SB_CB  = 4;

endpackage

// File: rtl/fdc_pst_cmd_decode.sv
module fdc_pst_cmd_decode
   import fdc_pst_pkg::*;
#(
   parameter int CNT_W          = 4,
   parameter int XFER_CMD_BYTES = 9,
   parameter int XFER_RES_BYTES = 7
) (
   input  logic [7:0]       opcode,
   output cmd_kind_e        kind,
   output logic [CNT_W-1:0] n_cmd,
   output logic [CNT_W-1:0] n_res,
   output logic             has_exec
);

   if ((1 << CNT_W) <= XFER_CMD_BYTES || (1 << CNT_W) <= XFER_RES_BYTES) begin : g_bad_cnt
      $error("cmd_decode: CNT_W too narrow for the transfer byte counts");
   end

   always_comb begin
      kind     = CK_BAD;
      n_cmd    = CNT_W'(1);
      n_res    = CNT_W'(1);
      has_exec = 1'b0;
      if (opcode == OP_SEEK) begin
         kind  = CK_SEEK;
         n_cmd = CNT_W'(3);
         n_res = '0;
      end else if (opcode == OP_RECAL) begin
         kind  = CK_RECAL;
         n_cmd = CNT_W'(2);
         n_res = '0;
      end else if (opcode == OP_SENSE) begin
         kind  = CK_SENSE;
         n_cmd = CNT_W'(1);
         n_res = CNT_W'(2);
      end else if (opcode[4:0] == OP_XFER_LO) begin
         kind     = CK_XFER;
         n_cmd    = CNT_W'(XFER_CMD_BYTES);
         n_res    = CNT_W'(XFER_RES_BYTES);
         has_exec = 1'b1;
      end
   end

endmodule

// File: rtl/fdc_pst_ready_timer.sv
module fdc_pst_ready_timer #(
   parameter int RDY_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic ready
);

   if (RDY_LAT < 0) begin : g_bad_lat
      $error("ready_timer: RDY_LAT must not be negative");
   end

   if (RDY_LAT == 0) begin : g_instant
      assign ready = 1'b1;
   end else begin : g_counted
      localparam int TW = $clog2(RDY_LAT + 1);
      logic [TW-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              hold_q <= '0;
         else if (load)           hold_q <= TW'(RDY_LAT);
         else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
      end

      assign ready = (hold_q == '0);

      AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         load |=> !ready); // R2
   end

endmodule

// File: rtl/fdc_pst_drive_busy.sv
module fdc_pst_drive_busy
   import fdc_pst_pkg::*;
#(
   parameter int NUM_DRIVES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  set_en,
   input  logic [DRV_W-1:0]      set_idx,
   input  logic                  clr_en,
   input  logic [DRV_W-1:0]      clr_idx,
   output logic [NUM_DRIVES-1:0] busy,
   output logic [DRV_W-1:0]      low_idx,
   output logic                  any_busy
);

   if (NUM_DRIVES < 1 || NUM_DRIVES > (1 << DRV_W)) begin : g_bad_drives
      $error("drive_busy: NUM_DRIVES out of range");
   end

   for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      busy[g] <= 1'b0;
         else if (set_en && set_idx == DRV_W'(g))         busy[g] <= 1'b1;
         else if (clr_en && clr_idx == DRV_W'(g))         busy[g] <= 1'b0;
      end

      AST_BUSY_CLEARED_BY_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(busy[g]) |-> $past(clr_en && clr_idx == DRV_W'(g))); // R5
   end

   always_comb begin
      low_idx = '0;
      for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
         if (busy[i]) low_idx = DRV_W'(i);
      end
   end

   assign any_busy = |busy;

endmodule

// File: rtl/fdc_phase_status.sv
module fdc_phase_status
   import fdc_pst_pkg::*;
#(
   parameter int NUM_DRIVES     = 4,
   parameter int RDY_LAT        = 2,
   parameter int XFER_CMD_BYTES = 9,
   parameter int XFER_RES_BYTES = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_stable,
   input  logic       dat_wr,
   input  logic [7:0] dat_wdata,
   input  logic       dat_rd,
   input  logic       exec_done,
   output logic [7:0] status,
   output logic [7:0] rd_data,
   output logic       irq,
   output logic       proto_err
);

   localparam int MAX_A = (XFER_CMD_BYTES > XFER_RES_BYTES) ? XFER_CMD_BYTES : XFER_RES_BYTES;
   localparam int MAX_B = (MAX_A > 3) ? MAX_A : 3;
   localparam int CNT_W = $clog2(MAX_B + 1);

   if (XFER_CMD_BYTES < 2 || XFER_RES_BYTES < 1) begin : g_bad_xfer
      $error("fdc_phase_status: transfer command needs >=2 bytes and >=1 result");
   end

   phase_e           phase_q;
   cmd_kind_e        kind_q, dec_kind;
   logic [CNT_W-1:0] cnt_q, ncmd_q, nres_q, dec_ncmd, dec_nres;
   logic             exec_q, dec_exec;
   logic [DRV_W-1:0] drv_q, rep_q, low_idx;
   logic             rep_v_q, any_busy;
   logic             osc_q, err_q, ready;
   logic [NUM_DRIVES-1:0] busy;
   logic [3:0]       busy4;
   logic             host_rqm, dio, acc_wr, acc_rd, bad_acc, last_cmd, last_res;
   logic             set_en, clr_en;
   logic [DRV_W-1:0] set_idx;
   logic [7:0]       status_raw;

   fdc_pst_cmd_decode #(
      .CNT_W(CNT_W), .XFER_CMD_BYTES(XFER_CMD_BYTES), .XFER_RES_BYTES(XFER_RES_BYTES)
   ) u_dec (
      .opcode(dat_wdata), .kind(dec_kind), .n_cmd(dec_ncmd), .n_res(dec_nres), .has_exec(dec_exec)
   );

   fdc_pst_ready_timer #(.RDY_LAT(RDY_LAT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(acc_wr | acc_rd), .ready(ready)
   );

   fdc_pst_drive_busy #(.NUM_DRIVES(NUM_DRIVES)) u_busy (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_en), .set_idx(set_idx),
      .clr_en(clr_en), .clr_idx(rep_q),
      .busy(busy), .low_idx(low_idx), .any_busy(any_busy)
   );

   // host-facing handshake
   assign dio      = (phase_q == PH_RES) || (phase_q == PH_EXEC);
   assign host_rqm = osc_q && ready && (phase_q != PH_EXEC);
   assign acc_wr   = dat_wr && !dat_rd && host_rqm && !dio;
   assign acc_rd   = dat_rd && !dat_wr && host_rqm && (phase_q == PH_RES);
   assign bad_acc  = (dat_wr || dat_rd) && !(acc_wr || acc_rd);
   assign irq      = (phase_q == PH_RES);

   assign last_cmd = ((cnt_q + 1'b1) == ncmd_q);
   assign last_res = ((cnt_q + 1'b1) == nres_q);

   // drive flag updates: drive byte is the second command byte
   assign set_en  = acc_wr && (phase_q == PH_CMD) && last_cmd &&
                    (kind_q == CK_SEEK || kind_q == CK_RECAL);
   assign set_idx = (cnt_q == CNT_W'(1)) ? dat_wdata[DRV_W-1:0] : drv_q;
   assign clr_en  = acc_rd && (kind_q == CK_SENSE) && (cnt_q == '0) && rep_v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (osc_stable) osc_q <= 1'b1;
         if (bad_acc)    err_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         kind_q  <= CK_BAD;
         cnt_q   <= '0;
         ncmd_q  <= '0;
         nres_q  <= '0;
         exec_q  <= 1'b0;
         drv_q   <= '0;
         rep_q   <= '0;
         rep_v_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: if (acc_wr) begin
               kind_q <= dec_kind;
               ncmd_q <= dec_ncmd;
               nres_q <= dec_nres;
               exec_q <= dec_exec;
               if (dec_ncmd == CNT_W'(1)) begin
                  cnt_q   <= '0;
                  rep_q   <= low_idx;
                  rep_v_q <= any_busy;
                  phase_q <= dec_exec ? PH_EXEC : (dec_nres != '0) ? PH_RES : PH_IDLE;
               end else begin
                  cnt_q   <= CNT_W'(1);
                  phase_q <= PH_CMD;
               end
            end
            PH_CMD: if (acc_wr) begin
               if (cnt_q == CNT_W'(1)) drv_q <= dat_wdata[DRV_W-1:0];
               if (last_cmd) begin
                  cnt_q   <= '0;
                  phase_q <= exec_q ? PH_EXEC : (nres_q != '0) ? PH_RES : PH_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_EXEC: if (exec_done) begin
               cnt_q   <= '0;
               phase_q <= PH_RES;
            end
            PH_RES: if (acc_rd) begin
               if (last_res) begin
                  cnt_q   <= '0;
                  phase_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      if (phase_q == PH_RES) begin
         case (kind_q)
            CK_SENSE: if (cnt_q == '0) rd_data = rep_v_q ? {{(8-DRV_W){1'b0}}, rep_q} : RES_INVALID;
            CK_BAD:   rd_data = RES_INVALID;
            default:  rd_data = '0;
         endcase
      end
   end

   assign busy4 = 4'(busy);

   always_comb begin
      status_raw         = {4'b0000, busy4};
      status_raw[SB_RQM] = (phase_q == PH_EXEC) ? irq : host_rqm;
      status_raw[SB_DIO] = dio;
      status_raw[SB_NDM] = (phase_q == PH_EXEC);
      status_raw[SB_CB]  = (phase_q != PH_IDLE);
   end

   assign status    = osc_q ? status_raw : 8'h00;
   assign proto_err = err_q;

   AST_CB_AFTER_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && phase_q == PH_IDLE) |=> status[SB_CB]); // R3

   AST_EXEC_RQM_IS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      status[SB_NDM] |-> (status[SB_RQM] == irq)); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err); // R10

   AST_IDLE_EXEC_DONE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_done && phase_q == PH_IDLE && !dat_wr) |=> (phase_q == PH_IDLE)); // R9

endmodule

// File: tb/fdc_phase_status_test.sv
module fdc_phase_status_test;

   localparam int CLK_PERIOD = 10;
   localparam int RDY_LAT    = 2;
   localparam int XFER_CMD   = 9;
   localparam int XFER_RES   = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_stable = 1'b0;
   logic       dat_wr = 1'b0;
   logic [7:0] dat_wdata = 8'h00;
   logic       dat_rd = 1'b0;
   logic       exec_done = 1'b0;
   logic [7:0] status, rd_data;
   logic       irq, proto_err;

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   fdc_phase_status #(
      .NUM_DRIVES(4), .RDY_LAT(RDY_LAT), .XFER_CMD_BYTES(XFER_CMD), .XFER_RES_BYTES(XFER_RES)
   ) uut (
      .clk(clk), .rst_n(rst_n), .osc_stable(osc_stable),
      .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .exec_done(exec_done),
      .status(status), .rd_data(rd_data), .irq(irq), .proto_err(proto_err)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wait_ready();
      int spins = 0;
      @(negedge clk);
      while (!status[7] && spins < 50) begin
         @(negedge clk);
         spins++;
      end
   endtask

   task automatic wr_byte(input logic [7:0] b);
      wait_ready();
      @(posedge clk) #1;
      dat_wr    = 1'b1;
      dat_wdata = b;
      @(posedge clk) #1;
      dat_wr    = 1'b0;
   endtask

   // driver: queue the expected result byte, then strobe the read
   task automatic rd_byte(input logic [7:0] exp, input string req);
      exp_q.push_back(exp);
      tag_q.push_back(req);
      wait_ready();
      @(posedge clk) #1;
      dat_rd = 1'b1;
      @(posedge clk) #1;
      dat_rd = 1'b0;
   endtask

   task automatic poke(input logic is_wr);
      @(posedge clk) #1;
      if (is_wr) dat_wr = 1'b1; else dat_rd = 1'b1;
      @(posedge clk) #1;
      dat_wr = 1'b0;
      dat_rd = 1'b0;
   endtask

   // monitor: compare each result byte while the read strobe is held
   always @(negedge clk) begin
      if (dat_rd && exp_q.size() > 0) begin
         logic [7:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, rd_data, e);
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R6 dark before osc", status, 8'h00);
      chk("R11 err clear at reset", {7'b0, proto_err}, 8'h00);

      @(posedge clk) #1 osc_stable = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R6 R1 idle after osc", status, 8'h80);

      // R10: read while direction is host-write
      poke(1'b0);
      @(negedge clk);
      chk("R10 bad read flags err", {7'b0, proto_err}, 8'h01);
      chk("R10 bad read ignored", status, 8'h80);

      // seek drive 2, checking the ready drop on its first byte
      wr_byte(8'h0F);
      @(negedge clk);
      chk("R2 ready drops after byte", status, 8'h10);
      repeat (RDY_LAT) @(posedge clk);
      @(negedge clk);
      chk("R2 R3 ready back, cmd busy", status, 8'h90);
      wr_byte(8'h02);
      wr_byte(8'h28);
      wait_ready();
      chk("R4 R3 seek sets drive2", status, 8'h84);

      // recalibrate drive 0
      wr_byte(8'h07);
      wr_byte(8'h00);
      wait_ready();
      chk("R4 recal sets drive0", status, 8'h85);

      // sense-interrupt reports drive 0 first
      wr_byte(8'h08);
      wait_ready();
      chk("R5 R1 sense result phase", status, 8'hD5);
      chk("R5 irq in result", {7'b0, irq}, 8'h01);
      rd_byte(8'h00, "R5 reports drive0");
      wait_ready();
      chk("R5 drive0 cleared", status, 8'hD4);
      rd_byte(8'h00, "R5 second byte");
      wait_ready();
      chk("R3 cb clears after results", status, 8'h84);

      wr_byte(8'h08);
      rd_byte(8'h02, "R5 reports drive2");
      rd_byte(8'h00, "R5 second byte");
      wait_ready();
      chk("R5 all drives free", status, 8'h80);

      // R10: write during result phase must not disturb it
      wr_byte(8'h08);
      wait_ready();
      chk("R5 none busy result phase", status, 8'hD0);
      poke(1'b1);
      @(negedge clk);
      chk("R10 bad write ignored", status, 8'hD0);
      rd_byte(8'h80, "R5 none busy reports 80");
      rd_byte(8'h00, "R5 second byte");

      // invalid opcode
      wr_byte(8'h1F);
      wait_ready();
      chk("R8 invalid result phase", status, 8'hD0);
      rd_byte(8'h80, "R8 invalid byte");
      wait_ready();
      chk("R8 back to idle", status, 8'h80);

      // data-transfer command with execution phase
      wr_byte(8'h46);
      for (int i = 1; i < XFER_CMD; i++) wr_byte(8'(i));
      @(negedge clk);
      chk("R7 execution status", status, 8'h70);
      chk("R7 irq low in exec", {7'b0, irq}, 8'h00);
      repeat (4) @(negedge clk);
      chk("R7 execution holds", status, 8'h70);
      @(posedge clk) #1 exec_done = 1'b1;
      @(posedge clk) #1 exec_done = 1'b0;
      @(negedge clk);
      chk("R7 result after exec_done", status, 8'hD0);
      chk("R7 irq in results", {7'b0, irq}, 8'h01);
      for (int i = 0; i < XFER_RES; i++) rd_byte(8'h00, "R7 transfer result");
      wait_ready();
      chk("R7 idle after results", status, 8'h80);
      chk("R7 irq drops", {7'b0, irq}, 8'h00);

      // exec_done while idle
      @(posedge clk) #1 exec_done = 1'b1;
      @(posedge clk) #1 exec_done = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 stray exec_done ignored", status, 8'h80);

      chk("R10 err still set", {7'b0, proto_err}, 8'h01);

      // reset mid-life: seek drive 1 then reset
      wr_byte(8'h0F);
      wr_byte(8'h01);
      wr_byte(8'h10);
      wait_ready();
      chk("R4 seek sets drive1", status, 8'h82);
      @(posedge clk) #1 rst_n = 1'b0;
      @(negedge clk);
      chk("R11 status dark in reset", status, 8'h00);
      chk("R11 err cleared", {7'b0, proto_err}, 8'h00);
      @(posedge clk) #1 rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R11 busy cleared after reset", status, 8'h80);

      if (exp_q.size() != 0) chk("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule